// File: doc/BRIEF.md
# Toggle-on-Write Interrupt Register Bank

This block gathers interrupt events from a peripheral and presents them to software through a small register bank on a plain synchronous read/write port. It holds four things: a pending-status register, a per-source enable register, a one-bit global enable, and a keyed soft-reset location. A rising edge on an event input marks that source as pending. Software acknowledges a pending source by writing a one to its status bit, which inverts the bit. Writing the same mask twice therefore first raises the bits and then clears them.

The number of implemented sources is a parameter from 0 to 32. The implemented bits are packed upward from bit 0, and every bit above them reads as zero. The reset value of each status bit is set by a parameter, so that status bits which a peripheral holds high from reset can come up as one. A single registered interrupt line is raised when the global enable is on and at least one pending source is also enabled. Writing a fixed key to the soft-reset location returns the whole bank to its reset state and turns the global enable off.

Top module: `irq_toggle_regs`

## Requirements
- R1: After the reset input, status reads STATUS_RST masked to the implemented bits, the enable register and the global enable read zero, and `irq` and `bus_rdata` are zero.
- R2: Only bits 0 to NUM_IRQ-1 exist. In both status and enable, bits at or above NUM_IRQ read zero and are unaffected by writes and events.
- R3: A write to word address 0 (status) inverts every implemented status bit whose write-data bit is one and leaves the rest unchanged, so the same mask written twice sets and then clears those bits.
- R4: A write to word address 1 (enable) stores the write data, and reads of that address return the implemented bits of the value last written.
- R5: Word address 2 holds the global enable in bit 0, written from write-data bit 0. Bits 31..1 of its read value are zero.
- R6: Writing RESET_KEY to word address 3 restores status to its reset value and clears the enable register and the global enable. Any other value written there changes nothing.
- R7: A 0-to-1 change on `evt_in[i]`, sampled at a clock edge, sets status bit i at that same edge. A level that stays high does not set the bit again after an acknowledge. When an event and a toggle write hit the same bit in one cycle, the bit ends set.
- R8: `irq` is high in the cycle after one in which the global enable is set and (status AND enable) is nonzero, and low in the cycle after one in which either condition fails.
- R9: `bus_rdata` shows the register selected by `bus_addr` one clock after the address is presented, using the state before any write in that same cycle. Address 3 and unmapped addresses read zero, and reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address of the register accessed |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the previous cycle's address |
| evt_in | input | DATA_W | Event inputs from the peripheral, rising-edge sensitive, bits at or above NUM_IRQ ignored |
| irq | output | 1 | Registered interrupt request |

## Verification
The properties assume that `rst` is held for at least two clocks at start-up. They also assume that the event inputs and the bus signals are stable around the sampling edge, so a 0-to-1 change is seen at exactly one edge. The bench drives every input on the falling edge and holds reset for several cycles, which satisfies both. It also runs the event-plus-write collision only through the same synchronous port, so the same-cycle priority rule is exercised without any asynchronous timing.

// File: rtl/irq_toggle_pkg.sv
package irq_toggle_pkg;

  // Word addresses of the register bank; the offsets are the software contract.
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_GIE    = 2'd2,
    SEL_SRST   = 2'd3
  } reg_sel_e;

  // Mask with the lowest n bits set (n in 0..64).
  function automatic logic [63:0] low_mask(input int n);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);

  logic [W-1:0] sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= '0;
    else     sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int          W       = 32,
  parameter int          NUM_IRQ = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [W-1:0] tgl_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] stat_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < NUM_IRQ) begin : g_impl
      logic bit_q;
      always_ff @(posedge clk) begin
        if (rst || clr_i)  bit_q <= RST_VAL[i];
        else if (set_i[i]) bit_q <= 1'b1;      // event wins over toggle
        else if (tgl_i[i]) bit_q <= ~bit_q;
      end
      assign stat_o[i] = bit_q;
    end else begin : g_absent
      assign stat_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int W       = 32,
  parameter int NUM_IRQ = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         en_we_i,
  input  logic         gie_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] en_o,
  output logic         gie_o,
  output logic         irq_o
);

  for (genvar i = 0; i < W; i++) begin : g_en
    if (i < NUM_IRQ) begin : g_impl
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst || clr_i) en_q <= 1'b0;
        else if (en_we_i) en_q <= wdata_i[i];
      end
      assign en_o[i] = en_q;
    end else begin : g_absent
      assign en_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i)  gie_o <= 1'b0;
    else if (gie_we_i) gie_o <= wdata_i[0];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= gie_o && (|(stat_i & en_o));
  end

endmodule

// File: rtl/irq_readback.sv
module irq_readback #(
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      stat_i,
  input  logic [W-1:0]      en_i,
  input  logic              gie_i,
  output logic [W-1:0]      rdata_o
);
  import irq_toggle_pkg::*;

  logic [W-1:0] sel_d;

  always_comb begin
    sel_d = '0;
    if (addr_i == ADDR_W'(SEL_STATUS))      sel_d = stat_i;
    else if (addr_i == ADDR_W'(SEL_ENABLE)) sel_d = en_i;
    else if (addr_i == ADDR_W'(SEL_GIE))    sel_d = {{(W-1){1'b0}}, gie_i};
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= sel_d;
  end

endmodule

// File: rtl/irq_toggle_regs.sv
module irq_toggle_regs #(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 4,
  parameter int              NUM_IRQ    = 8,
  parameter logic [DATA_W-1:0] STATUS_RST = '0,
  parameter logic [DATA_W-1:0] RESET_KEY  = 32'h0000_A5C3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] evt_in,
  output logic              irq
);
  import irq_toggle_pkg::*;

  localparam logic [DATA_W-1:0] IMPL_MASK = DATA_W'(low_mask(NUM_IRQ));

  logic [DATA_W-1:0] rise;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] en_q;
  logic              gie_q;
  logic              wr_stat, wr_en, wr_gie, soft_rst;

  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(SEL_STATUS));
  assign wr_en    = bus_wr && (bus_addr == ADDR_W'(SEL_ENABLE));
  assign wr_gie   = bus_wr && (bus_addr == ADDR_W'(SEL_GIE));
  assign soft_rst = bus_wr && (bus_addr == ADDR_W'(SEL_SRST)) && (bus_wdata == RESET_KEY);

  irq_edge_detect #(.W(DATA_W)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (evt_in & IMPL_MASK),
    .rise_o (rise)
  );

  irq_status_bank #(.W(DATA_W), .NUM_IRQ(NUM_IRQ), .RST_VAL(STATUS_RST)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (soft_rst),
    .tgl_i  (wr_stat ? bus_wdata : '0),
    .set_i  (rise),
    .stat_o (stat_q)
  );

  irq_ctrl_regs #(.W(DATA_W), .NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .clr_i    (soft_rst),
    .en_we_i  (wr_en),
    .gie_we_i (wr_gie),
    .wdata_i  (bus_wdata),
    .stat_i   (stat_q),
    .en_o     (en_q),
    .gie_o    (gie_q),
    .irq_o    (irq)
  );

  irq_readback #(.W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .stat_i  (stat_q),
    .en_i    (en_q),
    .gie_i   (gie_q),
    .rdata_o (bus_rdata)
  );

endmodule

// File: rtl/irq_toggle_regs_chk.sv
module irq_toggle_regs_chk #(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 4,
  parameter int              NUM_IRQ    = 8,
  parameter logic [DATA_W-1:0] STATUS_RST = '0,
  parameter logic [DATA_W-1:0] RESET_KEY  = 32'h0000_A5C3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] evt_in,
  input logic              irq,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] en_q,
  input logic              gie_q
);
  import irq_toggle_pkg::*;

  localparam logic [DATA_W-1:0] MASK = DATA_W'(low_mask(NUM_IRQ));

  logic [DATA_W-1:0] evt_prev;
  logic [DATA_W-1:0] chk_rise;
  logic              key_wr;

  always_ff @(posedge clk) begin
    if (rst) evt_prev <= '0;
    else     evt_prev <= evt_in;
  end

  assign chk_rise = evt_in & ~evt_prev & MASK;
  assign key_wr   = bus_wr && (bus_addr == ADDR_W'(3)) && (bus_wdata == RESET_KEY);

  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((stat_q & ~MASK) == '0) && ((en_q & ~MASK) == '0));

  // R3
  toggle_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(0) && chk_rise == '0)
    |=> stat_q == $past(stat_q ^ (bus_wdata & MASK)));

  // R4
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(1)) |=> en_q == $past(bus_wdata & MASK));

  // R6
  soft_reset_chk: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (en_q == '0) && !gie_q && (stat_q == (STATUS_RST & MASK)));

  // R7
  event_set_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_rise != '0 && !key_wr) |=> (stat_q & $past(chk_rise)) == $past(chk_rise));

  // R8
  irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == $past(gie_q && ((stat_q & en_q) != '0)));

  // R9
  read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_wr && chk_rise == '0) |=> $stable(stat_q) && $stable(en_q) && $stable(gie_q));

endmodule

bind irq_toggle_regs irq_toggle_regs_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_IRQ(NUM_IRQ),
  .STATUS_RST(STATUS_RST), .RESET_KEY(RESET_KEY)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .evt_in(evt_in), .irq(irq),
  .stat_q(stat_q), .en_q(en_q), .gie_q(gie_q)
);

// File: tb/irq_toggle_regs_bench.sv
module irq_toggle_regs_bench;

  localparam int          DW   = 32;
  localparam int          AW   = 4;
  localparam int          NIRQ = 12;
  localparam logic [31:0] SRST = 32'h0001_0005;
  localparam logic [31:0] KEY  = 32'h0000_A5C3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic [DW-1:0] evt_in = '0;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_toggle_regs #(
    .DATA_W(DW), .ADDR_W(AW), .NUM_IRQ(NIRQ), .STATUS_RST(SRST), .RESET_KEY(KEY)
  ) u_irq_toggle_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in), .irq(irq)
  );

  function automatic logic [31:0] impl_mask();
    logic [31:0] m = '0;
    for (int i = 0; i < NIRQ; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [31:0] MSK = impl_mask();

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  logic [31:0] m_stat, m_en, m_rd, m_evq, m_rise, m_ns, m_ne;
  logic        m_gie, m_irq, m_ng;

  always @(posedge clk) begin
    if (rst) begin
      m_stat <= SRST & MSK; m_en <= '0; m_gie <= 1'b0;
      m_rd <= '0; m_irq <= 1'b0; m_evq <= '0;
    end else begin
      case (bus_addr)
        4'd0:    m_rd <= m_stat;
        4'd1:    m_rd <= m_en;
        4'd2:    m_rd <= {31'b0, m_gie};
        default: m_rd <= '0;
      endcase
      m_irq  <= m_gie && ((m_stat & m_en) != 0);
      m_evq  <= evt_in;
      m_rise  = evt_in & ~m_evq & MSK;
      m_ns = m_stat; m_ne = m_en; m_ng = m_gie;
      if (bus_wr && bus_addr == 4'd3 && bus_wdata == KEY) begin
        m_ns = SRST & MSK; m_ne = '0; m_ng = 1'b0;
      end else begin
        if (bus_wr && bus_addr == 4'd0) m_ns = m_ns ^ (bus_wdata & MSK);
        m_ns = m_ns | m_rise;
        if (bus_wr && bus_addr == 4'd1) m_ne = bus_wdata & MSK;
        if (bus_wr && bus_addr == 4'd2) m_ng = bus_wdata[0];
      end
      m_stat <= m_ns; m_en <= m_ne; m_gie <= m_ng;
    end
  end

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R9 model rdata", bus_rdata, m_rd);
      check("R8 model irq", {31'b0, irq}, {31'b0, m_irq});
    end
  end

  task automatic do_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a;
    @(negedge clk); d = bus_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    do_read(4'd0, v); check("R1 status reset value masked (R2)", v, 32'h0000_0005);
    do_read(4'd1, v); check("R1 enable reset", v, 32'h0);
    do_read(4'd2, v); check("R1 gie reset", v, 32'h0);

    // R3 toggle writes
    do_write(4'd0, 32'h0000_00F0);
    do_read(4'd0, v); check("R3 first toggle sets", v, 32'h0000_00F5);
    do_write(4'd0, 32'h0000_00F0);
    do_read(4'd0, v); check("R3 second toggle clears", v, 32'h0000_0005);
    do_write(4'd0, 32'hFFFF_0000);
    do_read(4'd0, v); check("R2 upper status bits ignore writes", v, 32'h0000_0005);
    do_write(4'd0, 32'h0000_0005);
    do_read(4'd0, v); check("R3 reset-high bits acknowledged", v, 32'h0);

    // R4 enable
    do_write(4'd1, 32'hFFFF_FFFF);
    do_read(4'd1, v); check("R4 enable all, R2 masked", v, 32'h0000_0FFF);
    do_write(4'd1, 32'h0000_00A0);
    do_read(4'd1, v); check("R4 enable readback", v, 32'h0000_00A0);

    // R5 global enable
    do_write(4'd2, 32'hFFFF_FFFF);
    do_read(4'd2, v); check("R5 gie bit0 only", v, 32'h0000_0001);

    // R8 interrupt latency
    check("R8 no irq with nothing pending", {31'b0, irq}, 32'h0);
    do_write(4'd0, 32'h0000_0020);
    check("R8 irq not yet high (registered)", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R8 irq high one cycle after condition", {31'b0, irq}, 32'h1);
    do_write(4'd2, 32'h0);
    @(negedge clk);
    check("R8 irq low after gie cleared", {31'b0, irq}, 32'h0);
    do_write(4'd0, 32'h0000_0020);

    // R7 events
    @(negedge clk); evt_in = 32'h0000_0008;
    do_read(4'd0, v); check("R7 rising event sets bit", v, 32'h0000_0008);
    do_write(4'd0, 32'h0000_0008);
    do_read(4'd0, v); check("R7 held level does not re-set", v, 32'h0);
    @(negedge clk);
    evt_in = 32'h0000_0018; bus_addr = 4'd0; bus_wdata = 32'h0000_0010; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    do_read(4'd0, v); check("R7 event wins over toggle", v, 32'h0000_0010);
    @(negedge clk); evt_in = 32'h0010_0018;
    do_read(4'd0, v); check("R2 event above NUM_IRQ ignored", v, 32'h0000_0010);
    do_write(4'd0, 32'h0000_0010);
    @(negedge clk); evt_in = '0;

    // R6 soft reset
    do_write(4'd3, 32'h0000_1234);
    do_read(4'd1, v); check("R6 wrong key ignored", v, 32'h0000_00A0);
    do_write(4'd2, 32'h1);
    do_write(4'd0, 32'h0000_0040);
    do_write(4'd3, KEY);
    do_read(4'd0, v); check("R6 status back to reset value", v, 32'h0000_0005);
    do_read(4'd1, v); check("R6 enable cleared", v, 32'h0);
    do_read(4'd2, v); check("R6 gie cleared", v, 32'h0);

    // R9 read behaviour
    do_read(4'd3, v); check("R9 reset location reads zero", v, 32'h0);
    do_read(4'd7, v); check("R9 unmapped reads zero", v, 32'h0);
    do_read(4'd0, v);
    do_read(4'd0, v2); check("R9 repeated read unchanged", v2, v);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule